// File: doc/BRIEF.md
# Shirley background update engine

This block drives the iterative Shirley background refinement for one spectrum held in external RAMs. On a start request it reads the measured intensities at the two end indices of the fitting window, seeds the background memory over that window with a flat line at the upper-end intensity, and then loops. Each pass asks an external area unit to integrate the spectrum against the current background, waits for its completion, and then sweeps the window upward.

At each index of the sweep it reads the stored partial area and forms the fraction partial/total with a sequential restoring divider. It interpolates between the two end intensities with that fraction and writes the result over the old estimate. It also keeps the largest absolute change seen in the pass.

A pass whose largest change stays at or below the threshold ends the run as converged. A run that reaches the iteration cap first ends flagged as not converged. A total area of zero cannot be divided, so the fraction is taken as zero and a sticky error flag is raised.

Top module: `bg_refine_engine`

## Requirements
- R1: After `start_i`, I1 is the measurement at `lo_idx_i` and I2 the measurement at `hi_idx_i`. Before the first `area_start_o`, every background location from `lo_idx_i` to `hi_idx_i` is written once with I2, in ascending order, and no location outside that window is ever written.
- R2: Each pass raises `area_start_o` for exactly one cycle. After `area_done_i` it writes each index from `lo_idx_i` up to `hi_idx_i` exactly once, in ascending order.
- R3: For partial area A below total area T (T nonzero), the ratio is q = floor(A·2^FRAC / T). The value written is I2 + floor((I1 − I2)·q / 2^FRAC), with the floor taken toward minus infinity.
- R4: When A ≥ T and T is nonzero, q is 2^FRAC and the value written equals I1.
- R5: When T is zero, q is 0, the value written equals I2, and `div_err_o` goes high and stays high until the next accepted start.
- R6: The pass change is the maximum of |new − old| over the window. If it is at most `thr_i`, the run ends with `not_conv_o` low.
- R7: Otherwise another pass follows, unless the passes completed have reached max(`max_iter_i`, 1). In that case the run ends with `not_conv_o` high.
- R8: `done_o` pulses for one cycle at the end of a run with `busy_o` low. `iter_o` then equals the number of passes completed. `busy_o` is high from the cycle after start until that pulse.
- R9: `start_i` and the parameter inputs are ignored while `busy_o` is high.
- R10: Out of reset, `busy_o`, `done_o`, `not_conv_o`, `div_err_o`, `bg_we_o` and `area_start_o` are low and `iter_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken only when idle) |
| lo_idx_i | input | IW | Lower window index (must be ≤ upper) |
| hi_idx_i | input | IW | Upper window index |
| thr_i | input | DW | Convergence threshold on the pass change |
| max_iter_i | input | ITW | Pass cap (0 acts as 1) |
| area_start_o | output | 1 | One-cycle request to the area unit |
| area_done_i | input | 1 | Area unit finished; `amax_i` valid |
| amax_i | input | AW | Total area of the pass |
| meas_addr_o | output | IW | Measurement RAM address |
| meas_rdata_i | input | DW | Measurement RAM data, one cycle after address |
| a2_addr_o | output | IW | Partial-area RAM address |
| a2_rdata_i | input | AW | Partial-area RAM data, one cycle after address |
| bg_addr_o | output | IW | Background RAM address (read and write) |
| bg_rdata_i | input | DW | Background RAM data, one cycle after address |
| bg_we_o | output | 1 | Background RAM write enable |
| bg_wdata_o | output | DW | Background RAM write data (signed) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| not_conv_o | output | 1 | Run ended on the pass cap |
| div_err_o | output | 1 | A pass saw a zero total area |
| iter_o | output | ITW | Passes completed in the current or last run |

## Verification
The bench builds the engine with a 16-entry window space, 16-bit intensities, 20-bit areas, 10 fractional ratio bits and a 4-bit pass counter. The divider therefore spends ten cycles per point, and every window from a single point up to the full sixteen fits in a short run. That lets the bench sweep six windows, four spectrum shapes (peaked, flat, falling through negative values, rising) and two thresholds. Together these reach converged exits, capped exits, the zero-area error, the A ≥ T clamp and the zero pass cap. The bench models the area unit itself, so every written value, every pass change and each run's exit reason are predicted from integer arithmetic.

// File: rtl/bg_pkg.sv
package bg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LD_LO,
    ST_LD_HI,
    ST_LD_CAP,
    ST_FILL,
    ST_AREA_REQ,
    ST_AREA_WAIT,
    ST_RD,
    ST_CALC,
    ST_DIV,
    ST_WR,
    ST_EVAL
  } bg_state_e;

endpackage

// File: rtl/bg_div.sv
// Restoring divider, fractional quotient of num/den with num < den.
module bg_div #(
  parameter int AW   = 32,
  parameter int FRAC = 16,
  localparam int CW  = $clog2(FRAC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   num_i,
  input  logic [AW-1:0]   den_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [FRAC-1:0] quo_o
);

  logic [AW:0]     rem_q;
  logic [AW-1:0]   den_q;
  logic [FRAC-1:0] quo_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q;

  logic [AW:0] shl, sub;
  logic        ge;

  always_comb begin
    shl = rem_q << 1;
    ge  = shl >= {1'b0, den_q};
    sub = shl - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= {1'b0, num_i};
        den_q  <= den_i;
        quo_q  <= '0;
        cnt_q  <= CW'(FRAC);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? sub : shl;
        quo_q <= {quo_q[FRAC-2:0], ge};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R3: partial remainder never reaches the divisor
  a_r3_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/bg_interp.sv
// new = i2 + floor((i1 - i2) * ratio / 2^FRAC); delta = |new - old|
module bg_interp #(
  parameter int DW   = 16,
  parameter int FRAC = 16,
  localparam int PW  = DW + FRAC + 3
) (
  input  logic signed [DW-1:0] i1_i,
  input  logic signed [DW-1:0] i2_i,
  input  logic        [FRAC:0] ratio_i,
  input  logic signed [DW-1:0] old_i,
  output logic signed [DW-1:0] new_o,
  output logic        [DW:0]   delta_o
);

  logic signed [DW:0]     span;
  logic signed [FRAC+1:0] rs;
  logic signed [PW-1:0]   prod, shf, wide;
  logic signed [DW:0]     dd;

  always_comb begin
    span    = {i1_i[DW-1], i1_i} - {i2_i[DW-1], i2_i};
    rs      = {1'b0, ratio_i};
    prod    = PW'(span) * PW'(rs);
    shf     = prod >>> FRAC;
    wide    = PW'(i2_i) + shf;
    new_o   = wide[DW-1:0];
    dd      = {new_o[DW-1], new_o} - {old_i[DW-1], old_i};
    delta_o = dd[DW] ? $unsigned(-dd) : $unsigned(dd);
  end

  // R3: interpolated value lies between the endpoints, so no bits are lost
  always_comb begin
    a_r3_result_fits: assert (wide == PW'(new_o));
  end

endmodule

// File: rtl/bg_refine_engine.sv
module bg_refine_engine
  import bg_pkg::*;
#(
  parameter int NPTS = 512,
  parameter int DW   = 16,
  parameter int AW   = 32,
  parameter int FRAC = 16,
  parameter int ITW  = 8,
  localparam int IW  = $clog2(NPTS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [IW-1:0]  lo_idx_i,
  input  logic [IW-1:0]  hi_idx_i,
  input  logic [DW-1:0]  thr_i,
  input  logic [ITW-1:0] max_iter_i,
  output logic           area_start_o,
  input  logic           area_done_i,
  input  logic [AW-1:0]  amax_i,
  output logic [IW-1:0]  meas_addr_o,
  input  logic [DW-1:0]  meas_rdata_i,
  output logic [IW-1:0]  a2_addr_o,
  input  logic [AW-1:0]  a2_rdata_i,
  output logic [IW-1:0]  bg_addr_o,
  input  logic [DW-1:0]  bg_rdata_i,
  output logic           bg_we_o,
  output logic [DW-1:0]  bg_wdata_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           not_conv_o,
  output logic           div_err_o,
  output logic [ITW-1:0] iter_o
);

  localparam logic [FRAC:0] RATIO_ONE = {1'b1, {FRAC{1'b0}}};

  bg_state_e      state_q;
  logic [IW-1:0]  lo_q, hi_q, j_q;
  logic [DW-1:0]  thr_q, i1_q, i2_q, old_q;
  logic [ITW-1:0] maxit_q, iter_q, iter_nxt;
  logic [AW-1:0]  amax_q;
  logic [FRAC:0]  ratio_q;
  logic [DW:0]    maxd_q;
  logic           err_q, nc_q, done_q;

  logic            div_start, div_busy, div_done;
  logic [FRAC-1:0] div_quo;
  logic [DW-1:0]   new_val;
  logic [DW:0]     delta;

  assign div_start = (state_q == ST_CALC) && (amax_q != '0) && (a2_rdata_i < amax_q);
  assign iter_nxt  = iter_q + ITW'(1);

  bg_div #(.AW(AW), .FRAC(FRAC)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (a2_rdata_i),
    .den_i   (amax_q),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  bg_interp #(.DW(DW), .FRAC(FRAC)) u_interp (
    .i1_i    (i1_q),
    .i2_i    (i2_q),
    .ratio_i (ratio_q),
    .old_i   (old_q),
    .new_o   (new_val),
    .delta_o (delta)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      j_q     <= '0;
      thr_q   <= '0;
      i1_q    <= '0;
      i2_q    <= '0;
      old_q   <= '0;
      maxit_q <= '0;
      iter_q  <= '0;
      amax_q  <= '0;
      ratio_q <= '0;
      maxd_q  <= '0;
      err_q   <= 1'b0;
      nc_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          lo_q    <= lo_idx_i;
          hi_q    <= hi_idx_i;
          thr_q   <= thr_i;
          maxit_q <= max_iter_i;
          iter_q  <= '0;
          err_q   <= 1'b0;
          nc_q    <= 1'b0;
          state_q <= ST_LD_LO;
        end
        ST_LD_LO: state_q <= ST_LD_HI;
        ST_LD_HI: begin
          i1_q    <= meas_rdata_i;
          state_q <= ST_LD_CAP;
        end
        ST_LD_CAP: begin
          i2_q    <= meas_rdata_i;
          j_q     <= lo_q;
          state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (j_q == hi_q) state_q <= ST_AREA_REQ;
          else             j_q     <= j_q + IW'(1);
        end
        ST_AREA_REQ: state_q <= ST_AREA_WAIT;
        ST_AREA_WAIT: if (area_done_i) begin
          amax_q  <= amax_i;
          j_q     <= lo_q;
          maxd_q  <= '0;
          state_q <= ST_RD;
        end
        ST_RD: state_q <= ST_CALC;
        ST_CALC: begin
          old_q <= bg_rdata_i;
          if (amax_q == '0) begin
            ratio_q <= '0;
            err_q   <= 1'b1;
            state_q <= ST_WR;
          end else if (a2_rdata_i >= amax_q) begin
            ratio_q <= RATIO_ONE;
            state_q <= ST_WR;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          ratio_q <= {1'b0, div_quo};
          state_q <= ST_WR;
        end
        ST_WR: begin
          if (delta > maxd_q) maxd_q <= delta;
          if (j_q == hi_q) state_q <= ST_EVAL;
          else begin
            j_q     <= j_q + IW'(1);
            state_q <= ST_RD;
          end
        end
        ST_EVAL: begin
          iter_q <= iter_nxt;
          if (maxd_q <= {1'b0, thr_q}) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (iter_nxt >= maxit_q) begin
            nc_q    <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_AREA_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    meas_addr_o  = (state_q == ST_LD_LO) ? lo_q : hi_q;
    a2_addr_o    = j_q;
    bg_addr_o    = j_q;
    bg_we_o      = (state_q == ST_FILL) || (state_q == ST_WR);
    bg_wdata_o   = (state_q == ST_FILL) ? i2_q : new_val;
    area_start_o = (state_q == ST_AREA_REQ);
    busy_o       = (state_q != ST_IDLE);
    done_o       = done_q;
    not_conv_o   = nc_q;
    div_err_o    = err_q;
    iter_o       = iter_q;
  end

  a_r2_write_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_we_o |-> (bg_addr_o >= lo_q && bg_addr_o <= hi_q));

  a_r2_area_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    area_start_o |=> !area_start_o);

  a_r4_ratio_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR) |-> (ratio_q <= RATIO_ONE));

  a_r5_zero_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && amax_q == '0) |-> (ratio_q == '0 && err_q));

  a_r3_divider_idle_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> (state_q == ST_DIV));

  a_r7_cap_reached: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && not_conv_o) |-> (iter_o >= maxit_q && iter_o != '0));

  a_r8_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_window_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(lo_q) && $stable(hi_q) && $stable(thr_q)));

endmodule

// File: tb/tb_bg_refine_engine.sv
module tb_bg_refine_engine;

  localparam int NPTS = 16;
  localparam int DW   = 16;
  localparam int AW   = 20;
  localparam int FRAC = 10;
  localparam int ITW  = 4;
  localparam int IW   = 4;
  localparam logic signed [DW-1:0] SENT = 16'sh5A5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           start_i = 1'b0;
  logic [IW-1:0]  lo_i = '0, hi_i = '0;
  logic [DW-1:0]  thr_i = '0;
  logic [ITW-1:0] mi_i = '0;
  logic           area_start, area_done = 1'b0;
  logic [AW-1:0]  amax = '0;
  logic [IW-1:0]  meas_addr, a2_addr, bg_addr;
  logic [DW-1:0]  meas_rd, bg_rd, bg_wdata;
  logic [AW-1:0]  a2_rd;
  logic           bg_we, busy, done, nconv, derr;
  logic [ITW-1:0] iter;

  bg_refine_engine #(.NPTS(NPTS), .DW(DW), .AW(AW), .FRAC(FRAC), .ITW(ITW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .lo_idx_i(lo_i), .hi_idx_i(hi_i), .thr_i(thr_i), .max_iter_i(mi_i),
    .area_start_o(area_start), .area_done_i(area_done), .amax_i(amax),
    .meas_addr_o(meas_addr), .meas_rdata_i(meas_rd),
    .a2_addr_o(a2_addr), .a2_rdata_i(a2_rd),
    .bg_addr_o(bg_addr), .bg_rdata_i(bg_rd), .bg_we_o(bg_we), .bg_wdata_o(bg_wdata),
    .busy_o(busy), .done_o(done), .not_conv_o(nconv), .div_err_o(derr), .iter_o(iter)
  );

  logic signed [DW-1:0] meas_mem [NPTS];
  logic signed [DW-1:0] bg_mem   [NPTS];
  logic        [AW-1:0] a2_mem   [NPTS];

  always @(posedge clk) begin
    meas_rd <= meas_mem[meas_addr];
    a2_rd   <= a2_mem[a2_addr];
    bg_rd   <= bg_mem[bg_addr];
    if (bg_we) bg_mem[bg_addr] <= bg_wdata;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint spec(input int shape, input int k);
    case (shape)
      0:       return ((k < 8) ? 500 : 120) + ((k >= 5 && k <= 7) ? 700 : 0);
      1:       return 250;
      2:       return 300 - 40 * k;
      default: return 20 * k - 100;
    endcase
  endfunction

  // run state shared with the monitor
  int     r_lo, r_hi, r_thr, r_mi;
  longint e_i1, e_i2, amax_cur, maxd;
  int     phase, exp_j, pass_cnt, area_cnt;
  bit     stop_exp, last_conv, err_seen, run_done, mon_on;

  function automatic longint exp_val(input longint a2v, input longint tot);
    longint q;
    if (tot == 0)        q = 0;
    else if (a2v >= tot) q = longint'(1) << FRAC;
    else                 q = (a2v << FRAC) / tot;
    return e_i2 + (((e_i1 - e_i2) * q) >>> FRAC);
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (area_cnt > 0) begin
        area_cnt--;
        area_done = (area_cnt == 0);
      end else begin
        area_done = 1'b0;
      end
      if (bg_we) begin
        chk(busy == 1'b1, "R8 busy during write", busy, 1);
        chk(int'(bg_addr) == exp_j && phase != 2, "R2 write index order", bg_addr, exp_j);
        if (phase == 0) begin
          chk($signed(bg_wdata) == e_i2, "R1 flat seed value", $signed(bg_wdata), e_i2);
        end else if (phase == 1) begin
          longint a2v, ev, old, dlt;
          a2v = a2_mem[bg_addr];
          ev  = exp_val(a2v, amax_cur);
          old = bg_mem[bg_addr];
          if (amax_cur == 0)
            chk($signed(bg_wdata) == ev, "R5 zero total gives I2", $signed(bg_wdata), ev);
          else if (a2v >= amax_cur)
            chk($signed(bg_wdata) == ev, "R4 clamped ratio gives I1", $signed(bg_wdata), ev);
          else
            chk($signed(bg_wdata) == ev, "R3 interpolated value", $signed(bg_wdata), ev);
          dlt = (ev > old) ? ev - old : old - ev;
          if (dlt > maxd) maxd = dlt;
          if (exp_j == r_hi) begin
            pass_cnt++;
            last_conv = (maxd <= r_thr);
            stop_exp  = last_conv || (pass_cnt >= ((r_mi == 0) ? 1 : r_mi));
            phase = 2;
          end
        end
        exp_j++;
      end
      if (area_start) begin
        longint acc;
        chk((phase == 0 && exp_j == r_hi + 1) || (phase == 2 && !stop_exp),
            "R7 pass request timing", phase, 2);
        acc = 0;
        for (int k = r_hi; k >= r_lo; k--) begin
          acc += longint'(meas_mem[k]) - longint'(bg_mem[k]);
          a2_mem[k] = (acc < 0) ? '0 : AW'(acc);
        end
        amax_cur = a2_mem[r_lo];
        amax = AW'(amax_cur);
        if (amax_cur == 0) err_seen = 1'b1;
        phase = 1;
        exp_j = r_lo;
        maxd = 0;
        area_cnt = 3;
      end
      if (done) begin
        chk(phase == 2 && stop_exp, "R7 run end timing", phase, 2);
        if (last_conv) chk(nconv == 1'b0, "R6 converged exit flag", nconv, 0);
        else           chk(nconv == 1'b1, "R7 capped exit flag", nconv, 1);
        chk(int'(iter) == pass_cnt, "R8 pass count", iter, pass_cnt);
        chk(busy == 1'b0, "R8 idle at done", busy, 0);
        chk(derr == err_seen, "R5 error flag", derr, err_seen);
        run_done = 1'b1;
      end
    end
  end

  task automatic run(input int shape, input int lo, input int hi, input int thr,
                     input int mi, input bit poke);
    int cyc;
    @(negedge clk);
    for (int k = 0; k < NPTS; k++) begin
      meas_mem[k] = DW'(spec(shape, k));
      bg_mem[k]   = SENT;
      a2_mem[k]   = '0;
    end
    r_lo = lo; r_hi = hi; r_thr = thr; r_mi = mi;
    e_i1 = meas_mem[lo]; e_i2 = meas_mem[hi];
    phase = 0; exp_j = lo; pass_cnt = 0; maxd = 0; area_cnt = 0;
    stop_exp = 0; last_conv = 0; err_seen = 0; run_done = 0;
    lo_i = IW'(lo); hi_i = IW'(hi); thr_i = DW'(thr); mi_i = ITW'(mi);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!run_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin
        // R9: a second start with other settings while busy
        lo_i = 0; hi_i = IW'(NPTS - 1); thr_i = 16'd999; mi_i = 4'd1;
        start_i = 1'b1;
      end else if (poke && cyc == 41) begin
        start_i = 1'b0;
      end
    end
    chk(run_done, "R8 run completes", run_done, 1);
    for (int k = 0; k < NPTS; k++)
      if (k < lo || k > hi)
        chk(bg_mem[k] == SENT, "R1 outside window untouched", bg_mem[k], SENT);
    @(negedge clk);
    chk(done == 1'b0, "R8 done is one cycle", done, 0);
  endtask

  initial begin
    int lo_t[6] = '{0, 2, 5, 7, 0, 3};
    int hi_t[6] = '{15, 9, 5, 8, 1, 14};
    mon_on = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && nconv == 0 && derr == 0 && bg_we == 0 &&
        area_start == 0 && iter == 0, "R10 reset state", {busy, done, nconv, derr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && iter == 0, "R10 idle after reset", busy, 0);
    mon_on = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 6; r++)
        for (int t = 0; t < 2; t++)
          run(s, lo_t[r], hi_t[r], (t == 0) ? 0 : 20, (t == 0) ? 3 : 6, 1'b0);
    run(0, 0, 15, 20, 6, 1'b1);
    run(0, 2, 12, 0, 0, 1'b0);
    run(2, 1, 13, 0, 15, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule